// File: doc/BRIEF.md
# Processor Low-Power State Controller

This block decides which power state a processor core is in and when to leave it. It tracks seven states: running, halted, stopped (the core clock is gated off after a stop request), sleep, and three short service states. The service states cover a cache flush, system-management mode and a bus re-initialisation. Its inputs are a halt-instruction strobe, a stop request, a sleep request and a set of wake events. It drives a core-clock enable and one-cycle strobes that tell the bus interface to run a Halt cycle or a stop acknowledge cycle. It also drives a flush request, which is held until flush-done returns, and a strobe that enters management mode.

Four interrupt-class events can arrive while the clock is stopped or the core sleeps: management interrupt, init, NMI and INTR. They are not serviced then. Each one is recorded as a single pending flag, however many times it fires. When the controller next enters the running state, the flags are handed to the core as a one-cycle service vector and cleared. Returning to the halted state after a stop, a flush or management mode never issues a second Halt cycle.

Top module: `lp_state_ctrl`

## Requirements
- R1: After the asynchronous reset, state_o is 0 (running), core_clk_en_o is 1, every strobe is 0, pend_o is 0 and svc_o is 0.
- R2: A halt_i pulse while running moves to state 1 (halted). halt_cyc_o is high for exactly the first cycle of that state.
- R3: While halted, any of ext_rst_i, bus_init_i, cpu_init_i, nmi_i or intr_i returns to state 0. If events arrive together, priority runs from ext_rst_i, then bus_init_i, flush_i, mgmt_irq_i, cpu_init_i, nmi_i, down to intr_i. For example, flush with mgmt and NMI gives the flush state, and mgmt with NMI gives management mode.
- R4: stop_req_i while halted moves to state 2 (stopped) and pulses stop_ack_o for one cycle. Dropping stop_req_i there returns to state 1 with halt_cyc_o low. While running, stop_req_i also enters state 2 with the acknowledge, and dropping it returns to state 0.
- R5: mgmt_irq_i while halted or running enters state 5 (management mode) and pulses mgmt_entry_o. On mgmt_exit_i the controller goes to state 1 without a Halt strobe if mode was entered from halted and resume_halt_i is 1. Otherwise it goes to state 0.
- R6: flush_i while halted enters state 4 with flush_req_o high until flush_done_i. It then returns to state 1 with halt_cyc_o low.
- R7: In states 2 and 3, pulses on mgmt_irq_i, cpu_init_i, nmi_i and intr_i set pend_o bits 3, 2, 1 and 0, one flag per event, and are not serviced. On the next entry to state 0, svc_o shows those bits for exactly one cycle and pend_o clears. A halted state holding pending flags moves to state 0 on the following cycle.
- R8: In state 2, bus_init_i enters state 6 for one cycle, and flush_i enters state 4 until flush_done_i. After either, the controller goes back to state 2 if stop_req_i is still high, and to state 0 otherwise.
- R9: ext_rst_i in state 2 clears all pending flags and forgets a halted origin. The controller stays in state 2 until stop_req_i drops, then goes to state 0.
- R10: sleep_req_i in state 2 enters state 3 (sleep), and dropping it returns to state 2. core_clk_en_o is low in states 2 and 3 and high in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Halt instruction retired |
| stop_req_i | input | 1 | Stop-clock request (level) |
| sleep_req_i | input | 1 | Sleep request (level) |
| nmi_i | input | 1 | Non-maskable interrupt |
| intr_i | input | 1 | Maskable interrupt |
| cpu_init_i | input | 1 | Soft init event |
| mgmt_irq_i | input | 1 | Management-mode interrupt |
| bus_init_i | input | 1 | Bus re-initialisation event |
| flush_i | input | 1 | Cache flush event |
| ext_rst_i | input | 1 | Reset event seen as a wake source |
| flush_done_i | input | 1 | Flush completed |
| mgmt_exit_i | input | 1 | Management handler returned |
| resume_halt_i | input | 1 | Resume halted state after management mode |
| state_o | output | 3 | Current state code |
| core_clk_en_o | output | 1 | Core clock enable |
| halt_cyc_o | output | 1 | Halt bus-cycle strobe |
| stop_ack_o | output | 1 | Stop acknowledge bus-cycle strobe |
| flush_req_o | output | 1 | Flush request, held until done |
| mgmt_entry_o | output | 1 | Management-mode entry strobe |
| pend_o | output | 4 | Pending flags {mgmt, init, nmi, intr} |
| svc_o | output | 4 | One-cycle service vector on entry to running |

## Verification
The hardest path to reach is a return to the halted state that still holds pending flags. To get there the core must halt, stop, sleep, collect interrupts in both gated states, wake and release the stop. Only then does the controller take its extra hop to running and hand over the service vector. The bench drives that whole chain in one directed task. A second task drops the stop request while a flush started from the stopped state is still in progress, so the flush completes into the running state rather than back into stopped.

// File: rtl/lp_pkg.sv
package lp_pkg;
  localparam int unsigned NUM_EV   = 7;
  localparam int unsigned NUM_PEND = 4;
  // wake-event indices, 0 = highest priority
  localparam int unsigned EV_RST   = 0;
  localparam int unsigned EV_BINIT = 1;
  localparam int unsigned EV_FLUSH = 2;
  localparam int unsigned EV_MGMT  = 3;
  localparam int unsigned EV_INIT  = 4;
  localparam int unsigned EV_NMI   = 5;
  localparam int unsigned EV_INTR  = 6;

  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_HALT  = 3'd1,
    ST_STOP  = 3'd2,
    ST_SLEEP = 3'd3,
    ST_FLUSH = 3'd4,
    ST_MGMT  = 3'd5,
    ST_BINIT = 3'd6
  } lp_state_e;
endpackage

// File: rtl/lp_wake_arb.sv
module lp_wake_arb #(
  parameter int unsigned N = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  logic [N-1:0] blk;

  for (genvar i = 0; i < N; i++) begin : g_prio
    if (i == 0) begin : g_top
      assign blk[i] = 1'b0;
    end else begin : g_rest
      assign blk[i] = blk[i-1] | req_i[i-1];
    end
    assign gnt_o[i] = req_i[i] & ~blk[i];
  end

  p_gnt_onehot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));
  p_gnt_any_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_i) |-> (|gnt_o));
endmodule

// File: rtl/lp_pend_flags.sv
module lp_pend_flags #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic         clr_i,
  input  logic         wipe_i,
  input  logic [N-1:0] evt_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] svc_o
);
  logic [N-1:0] pend_q, svc_q, merged;

  assign merged = pend_q | (cap_i ? evt_i : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      svc_q  <= '0;
    end else begin
      svc_q <= '0;
      if (wipe_i) begin
        pend_q <= '0;
      end else if (clr_i) begin
        svc_q  <= merged;
        pend_q <= '0;
      end else begin
        pend_q <= merged;
      end
    end
  end

  assign pend_o = pend_q;
  assign svc_o  = svc_q;

  p_pend_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !wipe_i) |=> ((pend_q & $past(pend_q)) == $past(pend_q)));
  p_svc_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|svc_q) |=> (svc_q == '0));
endmodule

// File: rtl/lp_state_ctrl.sv
module lp_state_ctrl
  import lp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       halt_i,
  input  logic       stop_req_i,
  input  logic       sleep_req_i,
  input  logic       nmi_i,
  input  logic       intr_i,
  input  logic       cpu_init_i,
  input  logic       mgmt_irq_i,
  input  logic       bus_init_i,
  input  logic       flush_i,
  input  logic       ext_rst_i,
  input  logic       flush_done_i,
  input  logic       mgmt_exit_i,
  input  logic       resume_halt_i,
  output logic [2:0] state_o,
  output logic       core_clk_en_o,
  output logic       halt_cyc_o,
  output logic       stop_ack_o,
  output logic       flush_req_o,
  output logic       mgmt_entry_o,
  output logic [3:0] pend_o,
  output logic [3:0] svc_o
);
  lp_state_e state_q, nxt;
  logic [NUM_EV-1:0]   evt, gnt;
  logic [NUM_PEND-1:0] int_evt, pend;
  logic org_halt_q, org_halt_d;   // stop entered from halted
  logic ret_stop_q, ret_stop_d;   // flush launched from stopped
  logic mgmt_halt_q, mgmt_halt_d; // mgmt entered from halted
  logic halt_d, ack_d, mgmt_d;
  logic halt_q, ack_q, mgmt_q, clk_en_q;
  logic cap, clr, wipe;

  assign evt = {intr_i, nmi_i, cpu_init_i, mgmt_irq_i, flush_i, bus_init_i, ext_rst_i};
  assign int_evt = {mgmt_irq_i, cpu_init_i, nmi_i, intr_i};

  lp_wake_arb #(.N(NUM_EV)) u_arb (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .req_i (evt),
    .gnt_o (gnt)
  );

  always_comb begin
    nxt         = state_q;
    org_halt_d  = org_halt_q;
    ret_stop_d  = ret_stop_q;
    mgmt_halt_d = mgmt_halt_q;
    halt_d      = 1'b0;
    ack_d       = 1'b0;
    mgmt_d      = 1'b0;
    wipe        = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (stop_req_i) begin
          nxt = ST_STOP; ack_d = 1'b1; org_halt_d = 1'b0;
        end else if (mgmt_irq_i) begin
          nxt = ST_MGMT; mgmt_d = 1'b1; mgmt_halt_d = 1'b0;
        end else if (halt_i) begin
          nxt = ST_HALT; halt_d = 1'b1;
        end
      end
      ST_HALT: begin
        if (gnt[EV_FLUSH]) begin
          nxt = ST_FLUSH; ret_stop_d = 1'b0;
        end else if (gnt[EV_MGMT]) begin
          nxt = ST_MGMT; mgmt_d = 1'b1; mgmt_halt_d = 1'b1;
        end else if (gnt[EV_RST] | gnt[EV_BINIT] | gnt[EV_INIT] | gnt[EV_NMI] | gnt[EV_INTR]) begin
          nxt = ST_RUN;
        end else if (|pend) begin
          nxt = ST_RUN;
        end else if (stop_req_i) begin
          nxt = ST_STOP; ack_d = 1'b1; org_halt_d = 1'b1;
        end
      end
      ST_STOP: begin
        if (evt[EV_RST]) begin
          wipe = 1'b1; org_halt_d = 1'b0;
          if (!stop_req_i) nxt = ST_RUN;
        end else if (evt[EV_BINIT]) begin
          nxt = ST_BINIT;
        end else if (evt[EV_FLUSH]) begin
          nxt = ST_FLUSH; ret_stop_d = 1'b1;
        end else if (!stop_req_i) begin
          nxt = org_halt_q ? ST_HALT : ST_RUN;
        end else if (sleep_req_i) begin
          nxt = ST_SLEEP;
        end
      end
      ST_SLEEP: begin
        if (!sleep_req_i) nxt = ST_STOP;
      end
      ST_FLUSH: begin
        if (flush_done_i) begin
          if (!ret_stop_q)     nxt = ST_HALT;
          else if (stop_req_i) nxt = ST_STOP;
          else                 nxt = ST_RUN;
        end
      end
      ST_MGMT: begin
        if (mgmt_exit_i) nxt = (mgmt_halt_q && resume_halt_i) ? ST_HALT : ST_RUN;
      end
      ST_BINIT: begin
        nxt = stop_req_i ? ST_STOP : ST_RUN;
      end
      default: nxt = ST_RUN;
    endcase
  end

  assign cap = (state_q == ST_STOP) || (state_q == ST_SLEEP);
  assign clr = (nxt == ST_RUN) && (state_q != ST_RUN);

  lp_pend_flags #(.N(NUM_PEND)) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (cap),
    .clr_i (clr),
    .wipe_i(wipe),
    .evt_i (int_evt),
    .pend_o(pend),
    .svc_o (svc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_RUN;
      org_halt_q  <= 1'b0;
      ret_stop_q  <= 1'b0;
      mgmt_halt_q <= 1'b0;
      halt_q      <= 1'b0;
      ack_q       <= 1'b0;
      mgmt_q      <= 1'b0;
      clk_en_q    <= 1'b1;
    end else begin
      state_q     <= nxt;
      org_halt_q  <= org_halt_d;
      ret_stop_q  <= ret_stop_d;
      mgmt_halt_q <= mgmt_halt_d;
      halt_q      <= halt_d;
      ack_q       <= ack_d;
      mgmt_q      <= mgmt_d;
      clk_en_q    <= !((nxt == ST_STOP) || (nxt == ST_SLEEP));
    end
  end

  assign state_o       = state_q;
  assign core_clk_en_o = clk_en_q;
  assign halt_cyc_o    = halt_q;
  assign stop_ack_o    = ack_q;
  assign mgmt_entry_o  = mgmt_q;
  assign flush_req_o   = (state_q == ST_FLUSH);
  assign pend_o        = pend;

  p_halt_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_cyc_o |-> (state_q == ST_HALT && $past(state_q) == ST_RUN));
  p_no_rehalt_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HALT && $past(state_q) != ST_RUN) |-> !halt_cyc_o);
  p_ack_entry_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_ack_o |-> (state_q == ST_STOP && $past(state_q) != ST_STOP));
  p_mgmt_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mgmt_entry_o |-> (state_q == ST_MGMT));
  p_clk_off_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_STOP || state_q == ST_SLEEP) |-> !core_clk_en_o);
  p_sleep_src_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SLEEP && $past(state_q) != ST_SLEEP) |-> $past(state_q) == ST_STOP);
endmodule

// File: tb/sim_lp_state_ctrl.sv
`timescale 1ns/1ps
module sim_lp_state_ctrl;
  localparam int B_RST = 0, B_BINIT = 1, B_FLUSH = 2, B_MGMT = 3,
                 B_INIT = 4, B_NMI = 5, B_INTR = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic halt, stop_req, sleep_req, flush_done, mgmt_exit, resume_halt;
  logic [6:0] ev;
  logic [2:0] state;
  logic clk_en, halt_cyc, stop_ack, flush_req, mgmt_entry;
  logic [3:0] pend, svc;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  lp_state_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .halt_i(halt), .stop_req_i(stop_req),
    .sleep_req_i(sleep_req), .nmi_i(ev[B_NMI]), .intr_i(ev[B_INTR]),
    .cpu_init_i(ev[B_INIT]), .mgmt_irq_i(ev[B_MGMT]), .bus_init_i(ev[B_BINIT]),
    .flush_i(ev[B_FLUSH]), .ext_rst_i(ev[B_RST]), .flush_done_i(flush_done),
    .mgmt_exit_i(mgmt_exit), .resume_halt_i(resume_halt), .state_o(state),
    .core_clk_en_o(clk_en), .halt_cyc_o(halt_cyc), .stop_ack_o(stop_ack),
    .flush_req_o(flush_req), .mgmt_entry_o(mgmt_entry), .pend_o(pend), .svc_o(svc)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic go_halt();
    halt = 1'b1; step(); halt = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 state", state, 0);
    chk("R1 clk_en", clk_en, 1);
    chk("R1 strobes", {halt_cyc, stop_ack, flush_req, mgmt_entry}, 0);
    chk("R1 pend", pend, 0);
    chk("R1 svc", svc, 0);
  endtask

  task automatic t_halt();
    go_halt();
    chk("R2 state", state, 1);
    chk("R2 halt strobe", halt_cyc, 1);
    step();
    chk("R2 strobe one cycle", halt_cyc, 0);
    chk("R10 clk_en in halt", clk_en, 1);
    ev = 7'b1 << B_NMI; step(); ev = '0;
    chk("R3 nmi wake", state, 0);
  endtask

  task automatic t_wake_all();
    int bits[5] = '{B_RST, B_BINIT, B_INIT, B_NMI, B_INTR};
    foreach (bits[i]) begin
      go_halt();
      ev = 7'b1 << bits[i]; step(); ev = '0;
      chk("R3 wake event", state, 0);
    end
  endtask

  task automatic t_prio();
    go_halt();
    ev = (7'b1 << B_FLUSH) | (7'b1 << B_MGMT) | (7'b1 << B_NMI); step(); ev = '0;
    chk("R3 flush wins", state, 4);
    chk("R6 flush req", flush_req, 1);
    step();
    chk("R6 flush held", flush_req, 1);
    flush_done = 1'b1; step(); flush_done = 1'b0;
    chk("R6 back to halt", state, 1);
    chk("R6 no halt strobe", halt_cyc, 0);
    ev = (7'b1 << B_MGMT) | (7'b1 << B_NMI); step(); ev = '0;
    chk("R3 mgmt over nmi", state, 5);
    chk("R5 mgmt strobe", mgmt_entry, 1);
    resume_halt = 1'b1; mgmt_exit = 1'b1; step(); mgmt_exit = 1'b0;
    chk("R5 resume halt", state, 1);
    chk("R5 no halt strobe", halt_cyc, 0);
    ev = 7'b1 << B_MGMT; step(); ev = '0;
    chk("R5 re-enter", state, 5);
    resume_halt = 1'b0; mgmt_exit = 1'b1; step(); mgmt_exit = 1'b0;
    chk("R5 resume run", state, 0);
  endtask

  task automatic t_stop_sleep();
    go_halt();
    stop_req = 1'b1; step();
    chk("R4 stopped", state, 2);
    chk("R4 ack", stop_ack, 1);
    chk("R10 clk off", clk_en, 0);
    step();
    chk("R4 ack one cycle", stop_ack, 0);
    ev = 7'b1 << B_NMI; step(); ev = '0; step();
    ev = (7'b1 << B_NMI) | (7'b1 << B_INTR); step(); ev = '0;
    chk("R7 latched", pend, 4'b0011);
    chk("R7 not serviced", state, 2);
    sleep_req = 1'b1; step();
    chk("R10 sleep", state, 3);
    chk("R10 clk off sleep", clk_en, 0);
    ev = 7'b1 << B_MGMT; step(); ev = '0;
    chk("R7 latched in sleep", pend, 4'b1011);
    sleep_req = 1'b0; step();
    chk("R10 back to stop", state, 2);
    stop_req = 1'b0; step();
    chk("R4 back to halt", state, 1);
    chk("R4 no halt strobe", halt_cyc, 0);
    chk("R7 still pending", pend, 4'b1011);
    step();
    chk("R7 wake to run", state, 0);
    chk("R7 svc", svc, 4'b1011);
    chk("R7 cleared", pend, 0);
    step();
    chk("R7 svc one cycle", svc, 0);
  endtask

  task automatic t_stop_service();
    stop_req = 1'b1; step();
    chk("R4 stop from run", state, 2);
    chk("R4 ack from run", stop_ack, 1);
    ev = 7'b1 << B_BINIT; step(); ev = '0;
    chk("R8 bus init", state, 6);
    chk("R10 clk on", clk_en, 1);
    step();
    chk("R8 back to stop", state, 2);
    chk("R8 no ack", stop_ack, 0);
    ev = 7'b1 << B_FLUSH; step(); ev = '0;
    chk("R8 flush", state, 4);
    stop_req = 1'b0; step();
    chk("R8 flush held", state, 4);
    flush_done = 1'b1; step(); flush_done = 1'b0;
    chk("R8 flush to run", state, 0);
    stop_req = 1'b1; step(); stop_req = 1'b0; step();
    chk("R4 stop drop to run", state, 0);
  endtask

  task automatic t_stop_reset();
    stop_req = 1'b1; step();
    ev = 7'b1 << B_INTR; step(); ev = '0;
    chk("R7 intr latched", pend, 4'b0001);
    ev = 7'b1 << B_RST; step(); ev = '0;
    chk("R9 stays stopped", state, 2);
    chk("R9 pend wiped", pend, 0);
    stop_req = 1'b0; step();
    chk("R9 to run", state, 0);
    chk("R9 svc empty", svc, 0);
  endtask

  initial begin
    halt = 0; stop_req = 0; sleep_req = 0; flush_done = 0;
    mgmt_exit = 0; resume_halt = 0; ev = '0;
    repeat (3) step();
    rst_ni = 1'b1;
    step();
    t_reset();
    t_halt();
    t_wake_all();
    t_prio();
    t_stop_sleep();
    t_stop_service();
    t_stop_reset();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule